// File: doc/BRIEF.md
# Link Width and Clock-Rate Setup Controller

This block keeps the lane-width and clock-rate settings for one end of a point-to-point link. After a cold reset it waits for the peer to announce its widest receiver. It then settles on the narrower of the two sides, and it forces the mandatory default clock-rate code. Until that exchange completes, the width output stays at the narrowest setting.

Software sees a small register window. One read-only word advertises the local maximum width and clock rate. Two staged registers hold the width and rate that software wants to use next. Values written there never touch the live outputs straight away. They are copied into the active settings only when a warm reset, a link-stop assertion or a software warm-reset request occurs. Writes that ask for more than the advertised capability are clamped to the capability.

Width codes throughout are: 0 = 2 lanes, 1 = 4 lanes, 2 = 8 lanes, and 3 is a reserved value treated as 8 lanes. Clock-rate code 0 is the 200 MHz default.

Top module: `link_setup_ctrl`

## Requirements
- R1: While and after a cold reset (`rst_n` low at a clock edge), `act_width` is 0, `act_freq` is 0, `hs_done` is 0 and `warm_req` is 0. The staged width (address 1, bits [1:0]) and the staged rate (address 2, bits [3:0]) read 0.
- R2: The first clock edge with `peer_valid` high after cold reset sets `hs_done`. At the same edge `act_width` and the staged width take min(local cap, peer code). A peer code of 3 counts as 2.
- R3: While `hs_done` is 0, `act_width` stays 0 and `act_freq` stays 0 (200 MHz), whatever warm reset, link-stop or control writes arrive.
- R4: Once `hs_done` is 1, it stays 1 until the next cold reset. Further `peer_valid` strobes change neither `act_width` nor the staged width.
- R5: Address 0 reads the width cap in bits [1:0] and the rate cap in bits [7:4], with every other bit 0. Writes to address 0 have no effect.
- R6: A write to address 1 stores min(data[1:0] with 3 counted as 2, width cap). A write to address 2 stores min(data[3:0], rate cap). Both read back at once, and neither changes `act_width` or `act_freq`.
- R7: After the handshake, a write to address 3 with bit 0 set copies the staged width and rate into `act_width`/`act_freq` at that edge. `warm_req` is high for the following cycle. A write to address 3 with bit 0 clear does nothing.
- R8: After the handshake, a rising edge of `link_stop` applies the staged values at that edge. Holding `link_stop` high applies nothing further.
- R9: After the handshake, every edge with `warm_rst_n` low applies the staged values. The staged registers keep their contents.
- R10: A cold reset discards the staged values. The staged width follows the handshake result and the staged rate returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset, synchronous, active low; applies staged settings |
| link_stop | input | 1 | Link-stop level; its rising edge applies staged settings |
| peer_valid | input | 1 | Strobe qualifying `peer_width` |
| peer_width | input | 2 | Peer maximum receiver width code |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| act_width | output | 2 | Active width code |
| act_freq | output | 4 | Active clock-rate code |
| hs_done | output | 1 | Width handshake complete |
| warm_req | output | 1 | One-cycle warm-reset request after a control write |

## Verification
The assertions assume that a peer strobe and a write to the staged width register never fall in the same cycle; if they did, the handshake result would win. They also assume that every input is driven to a known value from the first cycle of reset. The bench drives peer strobes and register writes in separate cycles. It holds all inputs at defined idle levels from time zero. Apply events are issued one at a time, so each one can be attributed to a single cause.

// File: rtl/lsc_pkg.sv
// Package: shared width codes, register addresses and the width clamp
// used by the link setup controller. Assumes 2-bit width codes.
package lsc_pkg;

    localparam int WCODE_W = 2;

    typedef enum logic [1:0] {
        WID_2   = 2'd0,
        WID_4   = 2'd1,
        WID_8   = 2'd2,
        WID_RSV = 2'd3
    } wid_code_e;

    localparam logic [1:0] WID_MIN = WID_2;

    localparam logic [1:0] ADDR_CAP    = 2'd0;
    localparam logic [1:0] ADDR_PEND_W = 2'd1;
    localparam logic [1:0] ADDR_PEND_F = 2'd2;
    localparam logic [1:0] ADDR_CTRL   = 2'd3;

    // Clamp a requested width code: reserved counts as widest, then limit to cap.
    function automatic logic [1:0] wid_clamp(input logic [1:0] req, input logic [1:0] cap);
        logic [1:0] r;
        r = (req == WID_RSV) ? WID_8 : req;
        return (r > cap) ? cap : r;
    endfunction

endpackage

// File: rtl/lsc_handshake.sv
// Width handshake: after cold reset, captures the first peer width strobe,
// resolves the narrower of local and peer width and raises done.
// Assumes peer_width is meaningful only while peer_valid is high.
module lsc_handshake
    import lsc_pkg::*;
#(
    parameter logic [1:0] WIDTH_CAP = WID_4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       peer_valid,
    input  logic [1:0] peer_width,
    output logic       hs_fire,
    output logic       hs_done,
    output logic [1:0] neg_width
);

    logic       done_q;
    logic [1:0] neg_q;

    assign hs_fire   = peer_valid && !done_q;
    assign hs_done   = done_q;
    assign neg_width = neg_q;

    // Latch the negotiated width once, on the first strobe after cold reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            neg_q  <= WID_MIN;
        end else if (hs_fire) begin
            done_q <= 1'b1;
            neg_q  <= wid_clamp(peer_width, WIDTH_CAP);
        end
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q); // R4
    AST_NEG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> $stable(neg_q)); // R4
    AST_NEG_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        neg_q <= WIDTH_CAP); // R2

endmodule

// File: rtl/lsc_regs.sv
// Register window: read-only capability word, clamped staged width and rate,
// and a control register whose bit 0 requests a warm reset.
// Assumes a peer strobe and a staged-width write do not coincide
// (the handshake result takes priority if they do).
module lsc_regs
    import lsc_pkg::*;
#(
    parameter logic [1:0]        WIDTH_CAP    = WID_4,
    parameter int                FREQ_W       = 4,
    parameter logic [FREQ_W-1:0] FREQ_CAP     = 4'd5,
    parameter logic [FREQ_W-1:0] FREQ_DEFAULT = 4'd0,
    parameter int                DATA_W       = 8,
    parameter int                ADDR_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hs_fire,
    input  logic [1:0]        neg_width,
    output logic [1:0]        pend_width,
    output logic [FREQ_W-1:0] pend_freq,
    output logic              ctrl_apply,
    output logic              warm_req
);

    localparam int FREQ_LSB = 4;

    logic [1:0]        pw_q;
    logic [FREQ_W-1:0] pf_q;
    logic              wreq_q;
    logic [FREQ_W-1:0] freq_req;
    logic [FREQ_W-1:0] freq_clamped;
    logic              wr_pw;
    logic              wr_pf;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata[DATA_W-1:FREQ_W];

    // Decode write strobes per register.
    always_comb begin
        wr_pw      = reg_wen && (reg_addr == ADDR_PEND_W);
        wr_pf      = reg_wen && (reg_addr == ADDR_PEND_F);
        ctrl_apply = reg_wen && (reg_addr == ADDR_CTRL) && reg_wdata[0];
    end

    // Saturate a requested rate to the advertised cap.
    always_comb begin
        freq_req     = reg_wdata[FREQ_W-1:0];
        freq_clamped = (freq_req > FREQ_CAP) ? FREQ_CAP : freq_req;
    end

    // Staged width: handshake result first, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q <= WID_MIN;
        end else if (hs_fire) begin
            pw_q <= wid_clamp(neg_width_next(), WIDTH_CAP);
        end else if (wr_pw) begin
            pw_q <= wid_clamp(reg_wdata[1:0], WIDTH_CAP);
        end
    end

    // Staged rate: cold reset restores the default, writes are clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= FREQ_DEFAULT;
        end else if (wr_pf) begin
            pf_q <= freq_clamped;
        end
    end

    // Warm-reset request pulse, one cycle after the control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wreq_q <= 1'b0;
        end else begin
            wreq_q <= ctrl_apply;
        end
    end

    // Read mux for the register window.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CAP: begin
                reg_rdata[1:0]                 = WIDTH_CAP;
                reg_rdata[FREQ_LSB +: FREQ_W]  = FREQ_CAP;
            end
            ADDR_PEND_W: reg_rdata[1:0]        = pw_q;
            ADDR_PEND_F: reg_rdata[FREQ_W-1:0] = pf_q;
            default:     reg_rdata             = '0;
        endcase
    end

    // The handshake resolves the width in the same cycle it fires.
    function automatic logic [1:0] neg_width_next();
        return neg_width;
    endfunction

    assign pend_width = pw_q;
    assign pend_freq  = pf_q;
    assign warm_req   = wreq_q;

    AST_PEND_W_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pw_q <= WIDTH_CAP); // R6
    AST_PEND_F_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pf_q <= FREQ_CAP); // R6
    AST_PEND_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pf |=> $stable(pf_q)); // R9

endmodule

// File: rtl/lsc_active.sv
// Active settings: holds the live width and rate codes. The handshake loads
// the width; afterwards only a warm reset, a link-stop rising edge or a
// control request copies the staged values in. Assumes sync inputs.
module lsc_active
    import lsc_pkg::*;
#(
    parameter int                FREQ_W       = 4,
    parameter logic [FREQ_W-1:0] FREQ_DEFAULT = 4'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_fire,
    input  logic              hs_done,
    input  logic [1:0]        hs_width,
    input  logic [1:0]        pend_width,
    input  logic [FREQ_W-1:0] pend_freq,
    input  logic              ctrl_apply,
    input  logic              warm_rst_n,
    input  logic              link_stop,
    output logic [1:0]        act_width,
    output logic [FREQ_W-1:0] act_freq
);

    logic              stop_q;
    logic              stop_rise;
    logic              apply;
    logic [1:0]        w_q;
    logic [FREQ_W-1:0] f_q;

    // Remember the previous link-stop level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else begin
            stop_q <= link_stop;
        end
    end

    // An apply event counts only once the handshake has finished.
    always_comb begin
        stop_rise = link_stop && !stop_q;
        apply     = hs_done && (ctrl_apply || stop_rise || !warm_rst_n);
    end

    // Live settings: handshake load, then staged-value copies on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= WID_MIN;
            f_q <= FREQ_DEFAULT;
        end else if (hs_fire) begin
            w_q <= hs_width;
        end else if (apply) begin
            w_q <= pend_width;
            f_q <= pend_freq;
        end
    end

    assign act_width = w_q;
    assign act_freq  = f_q;

    AST_MIN_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_done |-> (w_q == WID_MIN && f_q == FREQ_DEFAULT)); // R3
    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_done && !apply) |=> ($stable(w_q) && $stable(f_q))); // R6
    AST_APPLY_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (w_q == $past(pend_width) && f_q == $past(pend_freq))); // R7

endmodule

// File: rtl/link_setup_ctrl.sv
// Top: link width and clock-rate setup for one link end. Wires the width
// handshake, the register window and the active-settings holder.
// Assumes all inputs are synchronous to clk; rst_n is the cold reset.
module link_setup_ctrl
    import lsc_pkg::*;
#(
    parameter logic [1:0]        WIDTH_CAP    = WID_4,
    parameter int                FREQ_W       = 4,
    parameter logic [FREQ_W-1:0] FREQ_CAP     = 4'd5,
    parameter logic [FREQ_W-1:0] FREQ_DEFAULT = 4'd0,
    parameter int                DATA_W       = 8,
    parameter int                ADDR_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              link_stop,
    input  logic              peer_valid,
    input  logic [1:0]        peer_width,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        act_width,
    output logic [FREQ_W-1:0] act_freq,
    output logic              hs_done,
    output logic              warm_req
);

    logic              hs_fire;
    logic [1:0]        neg_width;
    logic [1:0]        hs_width;
    logic [1:0]        pend_width;
    logic [FREQ_W-1:0] pend_freq;
    logic              ctrl_apply;

    // Width resolved in the firing cycle, fed to both staged and live copies.
    assign hs_width = wid_clamp(peer_width, WIDTH_CAP);

    lsc_handshake #(
        .WIDTH_CAP (WIDTH_CAP)
    ) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .peer_valid (peer_valid),
        .peer_width (peer_width),
        .hs_fire    (hs_fire),
        .hs_done    (hs_done),
        .neg_width  (neg_width)
    );

    lsc_regs #(
        .WIDTH_CAP    (WIDTH_CAP),
        .FREQ_W       (FREQ_W),
        .FREQ_CAP     (FREQ_CAP),
        .FREQ_DEFAULT (FREQ_DEFAULT),
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .hs_fire    (hs_fire),
        .neg_width  (hs_width),
        .pend_width (pend_width),
        .pend_freq  (pend_freq),
        .ctrl_apply (ctrl_apply),
        .warm_req   (warm_req)
    );

    lsc_active #(
        .FREQ_W       (FREQ_W),
        .FREQ_DEFAULT (FREQ_DEFAULT)
    ) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_fire    (hs_fire),
        .hs_done    (hs_done),
        .hs_width   (hs_width),
        .pend_width (pend_width),
        .pend_freq  (pend_freq),
        .ctrl_apply (ctrl_apply),
        .warm_rst_n (warm_rst_n),
        .link_stop  (link_stop),
        .act_width  (act_width),
        .act_freq   (act_freq)
    );

    AST_WIDTH_LE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        act_width <= WIDTH_CAP); // R2
    AST_FREQ_LE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        act_freq <= FREQ_CAP); // R6
    AST_HS_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_done) |-> (act_width == neg_width && pend_width == neg_width)); // R2

endmodule

// File: tb/link_setup_ctrl_bench.sv
module link_setup_ctrl_bench;

    localparam logic [1:0] WCAP = 2'd1;
    localparam logic [3:0] FCAP = 4'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic       link_stop = 1'b0;
    logic       peer_valid = 1'b0;
    logic [1:0] peer_width = 2'd0;
    logic       reg_wen = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] act_width;
    logic [3:0] act_freq;
    logic       hs_done;
    logic       warm_req;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    link_setup_ctrl #(.WIDTH_CAP(WCAP), .FREQ_CAP(FCAP)) u_link_setup_ctrl (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .link_stop(link_stop),
        .peer_valid(peer_valid), .peer_width(peer_width), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .act_width(act_width), .act_freq(act_freq), .hs_done(hs_done),
        .warm_req(warm_req)
    );

    function automatic int exp_w(input int c);
        int r;
        r = (c == 3) ? 2 : c;
        return (r > WCAP) ? WCAP : r;
    endfunction

    function automatic int exp_f(input int c);
        return (c > FCAP) ? FCAP : c;
    endfunction

    task automatic check(input string req, input int actual, input int expect_v);
        n_chk++;
        if (actual != expect_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expect_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        tick();
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic cold_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int d;
        int ew;
        int cw;
        int cf;
        for (int p = 0; p < 4; p++) begin
            cold_reset();
            // R1 reset state and R10 staged values cleared
            check("R1 act_width", int'(act_width), 0);
            check("R1 act_freq", int'(act_freq), 0);
            check("R1 hs_done", int'(hs_done), 0);
            check("R1 warm_req", int'(warm_req), 0);
            rd(2'd1, d); check("R10 pend width", d, 0);
            rd(2'd2, d); check("R10 pend freq", d, 0);
            // R5 capability word and ignored write
            rd(2'd0, d); check("R5 cap", d, (int'(FCAP) << 4) | int'(WCAP));
            wr(2'd0, 8'h00);
            rd(2'd0, d); check("R5 cap after write", d, (int'(FCAP) << 4) | int'(WCAP));
            // R3 apply events ignored before handshake
            wr(2'd2, 8'd3);
            wr(2'd3, 8'd1);
            check("R3 freq before done", int'(act_freq), 0);
            link_stop = 1'b1; tick(); link_stop = 1'b0; tick();
            warm_rst_n = 1'b0; tick(); warm_rst_n = 1'b1;
            check("R3 width before done", int'(act_width), 0);
            check("R3 freq before done 2", int'(act_freq), 0);
            // R2 handshake
            ew = exp_w(p);
            peer_width = 2'(p); peer_valid = 1'b1; tick(); peer_valid = 1'b0;
            check("R2 hs_done", int'(hs_done), 1);
            check("R2 act_width", int'(act_width), ew);
            check("R2 act_freq default", int'(act_freq), 0);
            rd(2'd1, d); check("R10 pend width = handshake", d, ew);
            // R4 later strobes ignored
            peer_width = 2'(p ^ 1); peer_valid = 1'b1; tick(); peer_valid = 1'b0;
            check("R4 hs_done held", int'(hs_done), 1);
            check("R4 act_width held", int'(act_width), ew);
            rd(2'd1, d); check("R4 pend width held", d, ew);
            cw = ew;
            cf = 0;
            // R6..R9 sweep over every width and rate request
            for (int w = 0; w < 4; w++) begin
                for (int f = 0; f < 16; f++) begin
                    wr(2'd1, 8'(w) | 8'hFC);
                    wr(2'd2, 8'(f) | 8'hF0);
                    rd(2'd1, d); check("R6 pend width", d, exp_w(w));
                    rd(2'd2, d); check("R6 pend freq", d, exp_f(f));
                    check("R6 width unchanged", int'(act_width), cw);
                    check("R6 freq unchanged", int'(act_freq), cf);
                    cw = exp_w(w);
                    cf = exp_f(f);
                    case ((w * 16 + f) % 3)
                        0: begin
                            wr(2'd3, 8'd0);
                            check("R7 bit0 clear no apply", int'(warm_req), 0);
                            wr(2'd3, 8'd1);
                            check("R7 apply width", int'(act_width), cw);
                            check("R7 apply freq", int'(act_freq), cf);
                            check("R7 warm_req high", int'(warm_req), 1);
                            tick();
                            check("R7 warm_req low", int'(warm_req), 0);
                        end
                        1: begin
                            link_stop = 1'b1; tick();
                            check("R8 apply width", int'(act_width), cw);
                            check("R8 apply freq", int'(act_freq), cf);
                            wr(2'd1, 8'd0);
                            wr(2'd2, 8'd0);
                            tick();
                            check("R8 held level no apply w", int'(act_width), cw);
                            check("R8 held level no apply f", int'(act_freq), cf);
                            link_stop = 1'b0; tick();
                        end
                        default: begin
                            warm_rst_n = 1'b0; tick(); warm_rst_n = 1'b1;
                            check("R9 apply width", int'(act_width), cw);
                            check("R9 apply freq", int'(act_freq), cf);
                            rd(2'd1, d); check("R9 pend width kept", d, cw);
                            rd(2'd2, d); check("R9 pend freq kept", d, cf);
                        end
                    endcase
                end
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule